// File: doc/BRIEF.md
# Grayscale Frame Modulation Unit

This unit decides, for every pixel of a passive STN panel and every frame, whether the dot is driven on. It takes a stored 4-bit pixel code, the current frame index and the pixel's row and column. It first applies the display mode: normal, reverse, or blanked to a background shade. It then maps the resulting code through a writable 16-entry gamma table to a 5-bit gray level. Finally it spreads that level over a repeating cycle of frames.

The cycle is 32 frames long in 32-level mode and 16 frames long otherwise. A dot is lit when its level exceeds a dithered phase. The phase is the sum of frame index, row and column, folded to the cycle length. Because the phase depends on the pixel's position, neighbouring pixels of the same level light up in different frames, which reduces flicker.

The gamma table and the mode bits live inside the unit. A synchronous software reset returns them to their power-up values. The on/off decision is registered and appears one clock after the pixel is presented.

Top module: `gray_fm_unit`

## Requirements
- R1: While rst_ni is low, and after its release with no pixel presented, dot_valid_o and dot_o are 0.
- R2: dot_valid_o equals the pix_valid_i of the previous clock, except after a cycle with soft_rst_i high, when it is 0.
- R3: After reset the gamma table holds, for codes 0 to 15: 0, 2, 4, 6, 12, 13, 14, 15, 8, 9, 10, 11, 19, 23, 27, 31.
- R4: A clock with tbl_we_i high stores tbl_data_i in entry tbl_addr_i. Pixels presented in that same clock still see the old entry. Pixels from the next clock on see the new one.
- R5: In 32-level mode (lvl32 = 1), dot_o is 1 exactly when the level is greater than (frame_i + row_i + col_i) mod 32.
- R6: In 16-level mode (lvl32 = 0), the phase is (frame_i + row_i + col_i) mod 16, and a table level above 15 acts as 15.
- R7: With reverse set and display-off clear, the code looked up is 15 minus pix_i.
- R8: With display-off set and reverse clear, every pixel uses code 15 minus the background color.
- R9: With display-off and reverse both set, every pixel uses the background color as its code.
- R10: A clock with soft_rst_i high restores the table and the mode register to their defaults: lvl32 = 1, reverse = 0, off = 0, background = 0. A table or mode write in the same clock is discarded, and the next output is invalid.
- R11: For a fixed pixel position, a level L lights the dot in exactly L frames of each 32-frame cycle in 32-level mode. In 16-level mode it lights the dot in min(L,15) frames of each 16-frame cycle.
- R12: dot_o is 0 whenever dot_valid_o is 0.
- R13: A clock with mode_we_i high loads lvl32, reverse, off and background from mode_lvl32_i, mode_rev_i, mode_off_i and mode_bg_i. Pixels see the new mode from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous return to defaults |
| tbl_we_i | input | 1 | Gamma table write strobe |
| tbl_addr_i | input | 4 | Gamma table entry to write |
| tbl_data_i | input | 5 | Gray level to store |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_lvl32_i | input | 1 | 1: 32-frame cycle, 0: 16-frame cycle |
| mode_rev_i | input | 1 | Reverse pixel codes |
| mode_off_i | input | 1 | Blank to background shade |
| mode_bg_i | input | 4 | Background color code |
| pix_valid_i | input | 1 | Pixel present this clock |
| pix_i | input | 4 | Stored pixel code |
| frame_i | input | 5 | Frame index |
| row_i | input | 8 | Pixel row |
| col_i | input | 8 | Pixel column |
| dot_valid_o | output | 1 | dot_o carries a decision |
| dot_o | output | 1 | Dot on in this frame |

## Verification
Each pixel code is swept through a full frame cycle at a fixed position, so the number of lit frames exposes the stored table level directly. The sweep is done with the default table, after table writes, and in 16-level mode, where entries above 15 show the saturation. Pseudo-random codes, frames and positions are compared against a behavioural model every clock. This separates a wrong phase fold or a missing row or column term from a wrong table value. Fixed patterns under reverse and both display-off variants distinguish the complement from the background selection. Writes and pixels placed in the same clock, and a software reset that collides with writes, pin down the update order.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  localparam int unsigned PIX_W   = 4;
  localparam int unsigned LVL_W   = 5;
  localparam int unsigned TBL_N   = 1 << PIX_W;
  localparam int unsigned PIX_MAX = TBL_N - 1;

  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic lvl32;
    logic rev;
    logic off;
    pix_t bg;
  } mode_t;

  localparam mode_t MODE_DEFAULT = '{lvl32: 1'b1, rev: 1'b0, off: 1'b0, bg: '0};

  function automatic lvl_t tbl_default(input int unsigned idx);
    case (idx)
      0: return 5'd0;   1: return 5'd2;   2: return 5'd4;   3: return 5'd6;
      4: return 5'd12;  5: return 5'd13;  6: return 5'd14;  7: return 5'd15;
      8: return 5'd8;   9: return 5'd9;   10: return 5'd10; 11: return 5'd11;
      12: return 5'd19; 13: return 5'd23; 14: return 5'd27; default: return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/gfm_cfg_regs.sv
module gfm_cfg_regs
  import gfm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  soft_rst_i,
  input  logic  tbl_we_i,
  input  pix_t  tbl_addr_i,
  input  lvl_t  tbl_data_i,
  input  logic  mode_we_i,
  input  mode_t mode_i,
  input  pix_t  rd_addr_i,
  output lvl_t  rd_level_o,
  output mode_t mode_o
);
  lvl_t  tbl_q [TBL_N];
  mode_t mode_q;

  for (genvar i = 0; i < TBL_N; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      tbl_q[i] <= tbl_default(i);
      else if (soft_rst_i)                              tbl_q[i] <= tbl_default(i);
      else if (tbl_we_i && (tbl_addr_i == pix_t'(i)))   tbl_q[i] <= tbl_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mode_q <= MODE_DEFAULT;
    else if (soft_rst_i) mode_q <= MODE_DEFAULT;
    else if (mode_we_i)  mode_q <= mode_i;
  end

  assign rd_level_o = tbl_q[rd_addr_i];
  assign mode_o     = mode_q;
endmodule

// File: rtl/gfm_mode_map.sv
module gfm_mode_map
  import gfm_pkg::*;
(
  input  pix_t  pix_i,
  input  mode_t mode_i,
  output pix_t  code_o
);
  localparam pix_t FULL = pix_t'(PIX_MAX);

  always_comb begin
    unique case ({mode_i.off, mode_i.rev})
      2'b00:   code_o = pix_i;
      2'b01:   code_o = FULL - pix_i;
      2'b10:   code_o = FULL - mode_i.bg;
      default: code_o = mode_i.bg;
    endcase
  end
endmodule

// File: rtl/gfm_dither.sv
module gfm_dither
  import gfm_pkg::*;
#(
  parameter int unsigned FRAME_W = 5,
  parameter int unsigned COORD_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               valid_i,
  input  lvl_t               level_i,
  input  logic               lvl32_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [COORD_W-1:0] row_i,
  input  logic [COORD_W-1:0] col_i,
  output logic               valid_o,
  output logic               dot_o
);
  localparam int unsigned BASE_W = (COORD_W > FRAME_W) ? COORD_W : FRAME_W;
  localparam int unsigned SUM_W  = (BASE_W + 2 > LVL_W) ? BASE_W + 2 : LVL_W;
  localparam lvl_t        SAT16  = lvl_t'((1 << (LVL_W - 1)) - 1);

  logic [SUM_W-1:0] sum;
  lvl_t             phase, level_eff;
  logic             dot_d;

  assign sum = SUM_W'(frame_i) + SUM_W'(row_i) + SUM_W'(col_i);

  always_comb begin
    if (lvl32_i) begin
      phase     = sum[LVL_W-1:0];
      level_eff = level_i;
    end else begin
      phase     = {1'b0, sum[LVL_W-2:0]};
      level_eff = (level_i > SAT16) ? SAT16 : level_i;
    end
    dot_d = valid_i && (level_eff > phase);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dot_o   <= 1'b0;
    end else if (soft_rst_i) begin
      valid_o <= 1'b0;
      dot_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      dot_o   <= dot_d;
    end
  end
endmodule

// File: rtl/gray_fm_unit.sv
module gray_fm_unit
  import gfm_pkg::*;
#(
  parameter int unsigned FRAME_W = 5,
  parameter int unsigned COORD_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               tbl_we_i,
  input  logic [3:0]         tbl_addr_i,
  input  logic [4:0]         tbl_data_i,
  input  logic               mode_we_i,
  input  logic               mode_lvl32_i,
  input  logic               mode_rev_i,
  input  logic               mode_off_i,
  input  logic [3:0]         mode_bg_i,
  input  logic               pix_valid_i,
  input  logic [3:0]         pix_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [COORD_W-1:0] row_i,
  input  logic [COORD_W-1:0] col_i,
  output logic               dot_valid_o,
  output logic               dot_o
);
  mode_t mode_wr, mode_q;
  pix_t  code;
  lvl_t  level_w;

  assign mode_wr = '{lvl32: mode_lvl32_i, rev: mode_rev_i, off: mode_off_i, bg: mode_bg_i};

  gfm_cfg_regs u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .tbl_we_i   (tbl_we_i),
    .tbl_addr_i (tbl_addr_i),
    .tbl_data_i (tbl_data_i),
    .mode_we_i  (mode_we_i),
    .mode_i     (mode_wr),
    .rd_addr_i  (code),
    .rd_level_o (level_w),
    .mode_o     (mode_q)
  );

  gfm_mode_map u_map (
    .pix_i  (pix_i),
    .mode_i (mode_q),
    .code_o (code)
  );

  gfm_dither #(.FRAME_W(FRAME_W), .COORD_W(COORD_W)) u_dith (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .valid_i    (pix_valid_i),
    .level_i    (level_w),
    .lvl32_i    (mode_q.lvl32),
    .frame_i    (frame_i),
    .row_i      (row_i),
    .col_i      (col_i),
    .valid_o    (dot_valid_o),
    .dot_o      (dot_o)
  );
endmodule

// File: rtl/gfm_checker.sv
module gfm_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       soft_rst_i,
  input logic       pix_valid_i,
  input logic       dot_valid_o,
  input logic       dot_o,
  input logic [3:0] pix_i,
  input logic [3:0] code,
  input logic [4:0] level_w,
  input logic       mode_rev,
  input logic       mode_off,
  input logic [3:0] mode_bg
);
  p_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && !soft_rst_i) |=> dot_valid_o);
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pix_valid_i || soft_rst_i) |=> !dot_valid_o);
  p_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dot_valid_o |-> !dot_o);
  p_dark_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_w == 5'd0) |=> !dot_o);
  p_bg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_off && mode_rev) |-> (code == mode_bg));
  p_inv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_off && !mode_rev) |-> ((code + mode_bg) == 4'd15));
  p_rev_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_off && mode_rev) |-> ((code + pix_i) == 4'd15));
  p_srst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!mode_off && !mode_rev && mode_bg == 4'd0));
endmodule

bind gray_fm_unit gfm_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .soft_rst_i  (soft_rst_i),
  .pix_valid_i (pix_valid_i),
  .dot_valid_o (dot_valid_o),
  .dot_o       (dot_o),
  .pix_i       (pix_i),
  .code        (code),
  .level_w     (level_w),
  .mode_rev    (mode_q.rev),
  .mode_off    (mode_q.off),
  .mode_bg     (mode_q.bg)
);

// File: tb/gray_fm_unit_test.sv
module gray_fm_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       srst = 1'b0, twe = 1'b0, mwe = 1'b0;
  logic [3:0] taddr = '0, mbg = '0, pix = '0;
  logic [4:0] tdata = '0, frame = '0;
  logic       m32 = 1'b0, mrev = 1'b0, moff = 1'b0, pv = 1'b0;
  logic [7:0] row = '0, col = '0;
  logic       dv, dot;

  int checks = 0, fails = 0, cycles = 0;
  int tbl [16];
  int s32, srev, soff, sbg;
  int exp_v, exp_d, lit;
  bit done = 0;

  always #4 clk = ~clk;

  gray_fm_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(srst),
    .tbl_we_i(twe), .tbl_addr_i(taddr), .tbl_data_i(tdata),
    .mode_we_i(mwe), .mode_lvl32_i(m32), .mode_rev_i(mrev), .mode_off_i(moff), .mode_bg_i(mbg),
    .pix_valid_i(pv), .pix_i(pix), .frame_i(frame), .row_i(row), .col_i(col),
    .dot_valid_o(dv), .dot_o(dot)
  );

  function automatic int def_lvl(int i);
    int d [16] = '{0, 2, 4, 6, 12, 13, 14, 15, 8, 9, 10, 11, 19, 23, 27, 31};
    return d[i];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) tbl[i] = def_lvl(i);
    s32 = 1; srev = 0; soff = 0; sbg = 0;
  endtask

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // one clock: inputs set at a negedge, results compared at the next negedge
  task automatic tick(string req);
    int code, lv, ph;
    if (soff != 0) code = (srev != 0) ? sbg : 15 - sbg;
    else           code = (srev != 0) ? 15 - int'(pix) : int'(pix);
    lv = tbl[code];
    if (s32 == 0 && lv > 15) lv = 15;
    ph = (int'(frame) + int'(row) + int'(col)) % ((s32 != 0) ? 32 : 16);
    exp_v = (srst) ? 0 : int'(pv);
    exp_d = (exp_v != 0 && lv > ph) ? 1 : 0;
    if (srst) model_reset();
    else begin
      if (twe) tbl[taddr] = int'(tdata);
      if (mwe) begin s32 = int'(m32); srev = int'(mrev); soff = int'(moff); sbg = int'(mbg); end
    end
    @(negedge clk);
    check(req, int'(dv), exp_v);
    check(req, int'(dot), exp_d);
    lit += int'(dot);
    twe = 0; mwe = 0; srst = 0;
  endtask

  task automatic set_mode(bit l32, bit rv, bit of, int bg);
    mwe = 1; m32 = l32; mrev = rv; moff = of; mbg = 4'(bg); pv = 0;
    tick("R13");
  endtask

  // full frame cycle at one position, counting lit frames
  task automatic sweep(string req, int p, int r, int c, int n, int exp_lit);
    lit = 0;
    for (int f = 0; f < n; f++) begin
      pv = 1; pix = 4'(p); frame = 5'(f); row = 8'(r); col = 8'(c);
      tick(req);
    end
    pv = 0;
    check(req, lit, exp_lit);
  endtask

  initial begin
    model_reset();
    #3;
    check("R1", int'(dv), 0);
    check("R1", int'(dot), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    tick("R1");

    // R3 R11: default levels counted over a 32-frame cycle, varied positions
    for (int p = 0; p < 16; p++) sweep("R3", p, p * 3, 7 + p, 32, def_lvl(p));
    check("R11", lit, 31);

    // R5: pseudo-random pixels against the model
    for (int k = 0; k < 400; k++) begin
      pv = ($urandom % 4) != 0; pix = 4'($urandom); frame = 5'($urandom);
      row = 8'($urandom); col = 8'($urandom);
      tick("R5");
    end

    // R4: write same clock as pixel, then sweep the new value
    twe = 1; taddr = 4'd5; tdata = 5'd21; pv = 1; pix = 4'd5; frame = 0; row = 0; col = 0;
    tick("R4");
    sweep("R4", 5, 0, 0, 32, 21);
    twe = 1; taddr = 4'd0; tdata = 5'd31; pv = 0; tick("R4");
    sweep("R4", 0, 9, 200, 32, 31);

    // R6: 16-level mode, saturation of entries above 15
    set_mode(0, 0, 0, 0);
    sweep("R6", 15, 3, 4, 16, 15);
    sweep("R6", 3, 1, 2, 16, 6);
    sweep("R11", 12, 0, 0, 16, 15);
    for (int k = 0; k < 200; k++) begin
      pv = 1; pix = 4'($urandom); frame = 5'($urandom); row = 8'($urandom); col = 8'($urandom);
      tick("R6");
    end

    // R7: reverse
    set_mode(1, 1, 0, 0);
    sweep("R7", 1, 0, 0, 32, 27);
    for (int k = 0; k < 100; k++) begin
      pv = 1; pix = 4'($urandom); frame = 5'($urandom); row = 8'($urandom); col = 8'($urandom);
      tick("R7");
    end

    // R8: off, complemented background
    set_mode(1, 0, 1, 2);
    sweep("R8", 9, 5, 5, 32, 23);
    // R9: off and reverse, background itself
    set_mode(1, 1, 1, 2);
    sweep("R9", 9, 5, 5, 32, 4);
    for (int k = 0; k < 100; k++) begin
      pv = 1; pix = 4'($urandom); frame = 5'($urandom); row = 8'($urandom); col = 8'($urandom);
      mbg = 4'($urandom); mwe = (k % 7) == 0; m32 = 1; mrev = k[0]; moff = 1;
      tick("R9");
    end

    // R12: no pixel, no dot
    set_mode(1, 0, 0, 0);
    for (int k = 0; k < 20; k++) begin
      pv = 0; pix = 4'd15; frame = 5'(k); tick("R12");
    end

    // R10: software reset beats colliding writes, output cleared
    twe = 1; taddr = 4'd15; tdata = 5'd0; mwe = 1; m32 = 0; mrev = 1; moff = 1; mbg = 4'd7;
    srst = 1; pv = 1; pix = 4'd15; frame = 0; row = 0; col = 0;
    tick("R10");
    sweep("R10", 15, 0, 0, 32, 31);
    sweep("R10", 5, 0, 0, 32, 13);
    sweep("R10", 0, 0, 0, 32, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end
endmodule